// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block drives three clock outputs. Each output is built from one of five input clocks (slow, main, PLL A, PLL B, master) and divided by a power of two from 1 to 64. Software programs each output through a small register bus. A per-output configuration word picks the source and the divide. A pair of write-one set/clear registers turns outputs on and off, and a status word reports which outputs are on.

The block does not hide glitches when the source or divide changes. Software is expected to turn an output off, write its configuration, wait for that output's ready flag, and then turn it back on. The ready flag drops when the configuration is written. It returns once the newly chosen source clock has produced two rising edges and that event has crossed into the bus clock domain.

Top module: `prog_clk_out`

## Requirements
- R1: After reset every output is off and held low, the on-status word reads 0, and every configuration word reads 0 (slow clock, divide by 1).
- R2: A write to address 0 turns on each output whose bit (bit i for output i) is 1. Bits written as 0 leave that output's on/off state unchanged.
- R3: A write to address 1 turns off each output whose bit is 1, and bits written as 0 change nothing. An output that is off is held low from the cycle after the write.
- R4: A read of address 2 returns the on/off state of output i in bit i, with the upper bits at 0.
- R5: The configuration word of output i sits at address 4+i and reads back as written. Bits [2:0] select the source: 0 slow, 1 main, 2 PLL A, 3 PLL B, 4 master. Bits [6:4] hold the prescaler code, and bits 3 and 7 read 0.
- R6: With prescaler code n from 0 to 6, the output period is the source period times 2^n and the duty cycle is 50 %. Code 7 acts as code 6 (divide by 64).
- R7: Source codes 5, 6 and 7 hold the output low even when it is on, and that output's ready flag stays clear.
- R8: A read of address 3 returns output i's ready flag in bit i. The flag is 0 from the cycle after a write to that output's configuration word. It stays 0 for longer than one period of the new source. It sets after two rising edges of the new source plus two bus clock cycles.
- R9: The outputs are independent. Configuring or switching one output leaves the frequency of another running output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Source 0: slow clock |
| main_clk | input | 1 | Source 1: main clock |
| plla_clk | input | 1 | Source 2: PLL A clock |
| pllb_clk | input | 1 | Source 3: PLL B clock |
| master_clk | input | 1 | Source 4: master clock |
| bus_we | input | 1 | Write strobe, sampled on the rising edge of clk |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pck_o | output | 3 | Programmable clock outputs, bit i is output i |

## Verification
Output 0 is measured at all five sources and at prescaler codes 0, 1, 2, 3, 4, 6 and 7. Each source has a distinct period (64, 20, 10, 14 and 4 ns), so the measured period shows whether the mux picked the wrong source or the divider used the wrong tap. The high-time check catches a stage that toggles on the wrong edge. Set and clear writes with mixed 0 and 1 bits show whether zero bits are ignored. A reserved source code shows whether the output and ready flag stay quiet. The slow source, read part-way through its first period, shows whether the ready flag rises too early. Two outputs run on different sources at once, and one is re-measured after the other is reconfigured, to show that the channels do not share state.

// File: rtl/pcg_pkg.sv
`timescale 1ns/1ps
package pcg_pkg;
  localparam int unsigned NUM_OUT  = 3;
  localparam int unsigned NUM_SRC  = 5;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned PRES_W   = 3;
  localparam int unsigned MAX_PRES = 6;
  localparam int unsigned AW       = 4;
  localparam int unsigned DW       = 8;
  localparam int unsigned SRC_LSB  = 0;
  localparam int unsigned PRES_LSB = 4;

  localparam logic [AW-1:0] ADDR_SET  = AW'(0);
  localparam logic [AW-1:0] ADDR_CLR  = AW'(1);
  localparam logic [AW-1:0] ADDR_ON   = AW'(2);
  localparam logic [AW-1:0] ADDR_RDY  = AW'(3);
  localparam logic [AW-1:0] ADDR_CFG0 = AW'(4);

  typedef struct packed {
    logic [PRES_W-1:0] pres;
    logic [SEL_W-1:0]  src;
  } cfg_t;

  // Prescaler codes above the deepest stage fall back to the deepest stage.
  function automatic logic [PRES_W-1:0] clamp_pres(input logic [PRES_W-1:0] p);
    return (p > PRES_W'(MAX_PRES)) ? PRES_W'(MAX_PRES) : p;
  endfunction

  function automatic logic src_valid(input logic [SEL_W-1:0] s);
    return s < SEL_W'(NUM_SRC);
  endfunction

  function automatic logic [AW-1:0] cfg_addr(input int unsigned idx);
    return AW'(int'(ADDR_CFG0) + int'(idx));
  endfunction

  function automatic logic [DW-1:0] pack_cfg(input cfg_t c);
    logic [DW-1:0] w;
    w = '0;
    w[SRC_LSB +: SEL_W]   = c.src;
    w[PRES_LSB +: PRES_W] = c.pres;
    return w;
  endfunction

  function automatic cfg_t unpack_cfg(input logic [DW-1:0] w);
    cfg_t c;
    c.src  = w[SRC_LSB +: SEL_W];
    c.pres = w[PRES_LSB +: PRES_W];
    return c;
  endfunction
endpackage

// File: rtl/pcg_regs.sv
`timescale 1ns/1ps
module pcg_regs
  import pcg_pkg::*;
#(
  parameter int unsigned N = NUM_OUT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic [N-1:0]         ready_i,
  output logic [DW-1:0]        rdata,
  output logic [N-1:0]         on_o,
  output cfg_t [N-1:0]         cfg_o,
  output logic [N-1:0]         cfg_wr_o
);
  logic         set_hit;
  logic         clr_hit;
  logic [N-1:0] on_q;
  logic         unused_wbits;

  assign set_hit      = we && (addr == ADDR_SET);
  assign clr_hit      = we && (addr == ADDR_CLR);
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= '0;
    end else if (set_hit) begin
      on_q <= on_q | wdata[N-1:0];
    end else if (clr_hit) begin
      on_q <= on_q & ~wdata[N-1:0];
    end
  end

  assign on_o = on_q;

  for (genvar i = 0; i < N; i++) begin : g_cfg
    cfg_t cfg_q;
    assign cfg_wr_o[i] = we && (addr == cfg_addr(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
      end else if (cfg_wr_o[i]) begin
        cfg_q <= unpack_cfg(wdata);
      end
    end
    assign cfg_o[i] = cfg_q;
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_ON) begin
      rdata[N-1:0] = on_q;
    end else if (addr == ADDR_RDY) begin
      rdata[N-1:0] = ready_i;
    end else begin
      for (int i = 0; i < int'(N); i++) begin
        if (addr == cfg_addr(i)) rdata = pack_cfg(cfg_o[i]);
      end
    end
  end
endmodule

// File: rtl/pcg_ripple_div.sv
`timescale 1ns/1ps
module pcg_ripple_div #(
  parameter int unsigned STAGES = 6,
  parameter int unsigned PW     = 3
) (
  input  logic          clk_in,
  input  logic          hold_n,
  input  logic [PW-1:0] sel,
  output logic          clk_out
);
  logic [STAGES:0] tap;

  assign tap[0] = clk_in;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic stage_q;
    always_ff @(posedge tap[k] or negedge hold_n) begin
      if (!hold_n) stage_q <= 1'b0;
      else         stage_q <= ~stage_q;
    end
    assign tap[k+1] = stage_q;
  end

  assign clk_out = tap[sel];
endmodule

// File: rtl/pcg_ready_track.sv
`timescale 1ns/1ps
module pcg_ready_track #(
  parameter int unsigned SRC_EDGES = 2,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic src_clk,
  output logic ready
);
  logic                 clr_q;
  logic                 chain_rst;
  logic [SRC_EDGES-1:0] edge_q;
  logic [SYNC_LEN-1:0]  sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= cfg_wr;
  end

  assign chain_rst = !rst_n || clr_q;

  // Counts rising edges of the newly chosen source after the clear pulse.
  always_ff @(posedge src_clk or posedge chain_rst) begin
    if (chain_rst) edge_q <= '0;
    else           edge_q <= {edge_q[SRC_EDGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sync_q <= '0;
    else if (cfg_wr || clr_q) sync_q <= '0;
    else                     sync_q <= {sync_q[SYNC_LEN-2:0], edge_q[SRC_EDGES-1]};
  end

  assign ready = sync_q[SYNC_LEN-1];
endmodule

// File: rtl/pcg_channel.sv
`timescale 1ns/1ps
module pcg_channel
  import pcg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  cfg_t               cfg,
  input  logic               cfg_wr,
  input  logic [NUM_SRC-1:0] src_clks,
  output logic               pck,
  output logic               ready
);
  logic sel_clk;
  logic div_clk;
  logic hold_n;

  always_comb begin
    sel_clk = 1'b0;
    if (src_valid(cfg.src)) sel_clk = src_clks[cfg.src];
  end

  assign hold_n = rst_n && en;

  pcg_ripple_div #(
    .STAGES (MAX_PRES),
    .PW     (PRES_W)
  ) u_div (
    .clk_in  (sel_clk),
    .hold_n  (hold_n),
    .sel     (clamp_pres(cfg.pres)),
    .clk_out (div_clk)
  );

  pcg_ready_track #(
    .SRC_EDGES (2),
    .SYNC_LEN  (2)
  ) u_rdy (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .src_clk (sel_clk),
    .ready   (ready)
  );

  assign pck = en && div_clk;
endmodule

// File: rtl/prog_clk_out.sv
`timescale 1ns/1ps
module prog_clk_out
  import pcg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slow_clk,
  input  logic               main_clk,
  input  logic               plla_clk,
  input  logic               pllb_clk,
  input  logic               master_clk,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic [NUM_OUT-1:0] pck_o
);
  logic [NUM_SRC-1:0]       src_clks;
  logic [NUM_OUT-1:0]       on_w;
  logic [NUM_OUT-1:0]       ready_w;
  logic [NUM_OUT-1:0]       cfg_wr_w;
  cfg_t [NUM_OUT-1:0]       cfg_w;

  assign src_clks = {master_clk, pllb_clk, plla_clk, main_clk, slow_clk};

  pcg_regs #(.N(NUM_OUT)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .ready_i  (ready_w),
    .rdata    (bus_rdata),
    .on_o     (on_w),
    .cfg_o    (cfg_w),
    .cfg_wr_o (cfg_wr_w)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_ch
    pcg_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (on_w[i]),
      .cfg      (cfg_w[i]),
      .cfg_wr   (cfg_wr_w[i]),
      .src_clks (src_clks),
      .pck      (pck_o[i]),
      .ready    (ready_w[i])
    );
  end
endmodule

// File: rtl/pcg_sva.sv
`timescale 1ns/1ps
module pcg_sva
  import pcg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [AW-1:0]      bus_addr,
  input logic [DW-1:0]      bus_wdata,
  input logic [NUM_OUT-1:0] on_w,
  input logic [NUM_OUT-1:0] ready_w,
  input logic [NUM_OUT-1:0] cfg_wr_w,
  input cfg_t [NUM_OUT-1:0] cfg_w,
  input logic [NUM_OUT-1:0] pck_o
);
  logic unused_chk;
  assign unused_chk = ^{bus_wdata, cfg_w};

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
    a_r2_set_turns_on: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_SET && bus_wdata[i]) |=> on_w[i]);
    a_r2_zero_bit_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_SET && !bus_wdata[i]) |=> (on_w[i] == $past(on_w[i])));
    a_r3_clr_turns_off: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_CLR && bus_wdata[i]) |=> !on_w[i]);
    a_r3_off_is_low: assert property (@(posedge clk) disable iff (!rst_n)
      !on_w[i] |-> !pck_o[i]);
    a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !src_valid(cfg_w[i].src) |-> (!pck_o[i] && !ready_w[i]));
    a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_w[i] |=> !ready_w[i]);
  end
endmodule

bind prog_clk_out pcg_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .on_w      (on_w),
  .ready_w   (ready_w),
  .cfg_wr_w  (cfg_wr_w),
  .cfg_w     (cfg_w),
  .pck_o     (pck_o)
);

// File: tb/prog_clk_out_tb_top.sv
`timescale 1ns/1ps
module prog_clk_out_tb_top;
  import pcg_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slow_clk = 1'b0, main_clk = 1'b0, plla_clk = 1'b0, pllb_clk = 1'b0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NUM_OUT-1:0] pck_o;

  always #2  clk      = ~clk;
  always #32 slow_clk = ~slow_clk;
  always #10 main_clk = ~main_clk;
  always #5  plla_clk = ~plla_clk;
  always #7  pllb_clk = ~pllb_clk;

  prog_clk_out dut_i (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .main_clk(main_clk),
    .plla_clk(plla_clk), .pllb_clk(pllb_clk), .master_clk(clk),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pck_o(pck_o)
  );

  int n_chk = 0, n_fail = 0;
  int src_half [5] = '{32, 10, 5, 7, 2};

  function automatic int exp_period(input int src, input int pres);
    int p;
    p = (pres > 6) ? 6 : pres;
    return (2 * src_half[src]) << p;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic count_high(input int ch, output int highs);
    highs = 0;
    for (int k = 0; k < 70; k++) begin
      #3;
      if (pck_o[ch]) highs++;
    end
  endtask

  // Scoreboard: expected output periods queued by the driver.
  typedef struct { int ch; int period; string tag; } exp_t;
  exp_t exp_q[$];
  int mon_ch = 0;
  logic mon_sig;
  assign mon_sig = pck_o[mon_ch];

  initial begin
    forever begin
      exp_t it;
      time t0, t1, t2;
      wait (exp_q.size() > 0);
      it = exp_q[0];
      mon_ch = it.ch;
      #1;
      repeat (2) @(posedge mon_sig);
      @(posedge mon_sig); t0 = $time;
      @(negedge mon_sig); t1 = $time;
      @(posedge mon_sig); t2 = $time;
      check(int'(t2 - t0) == it.period, it.tag, int'(t2 - t0), it.period);
      check(int'(t1 - t0) == it.period / 2, {it.tag, " duty"}, int'(t1 - t0), it.period / 2);
      void'(exp_q.pop_front());
    end
  end

  task automatic expect_period(input int ch, input int src, input int pres, input string tag);
    exp_t it;
    it.ch = ch; it.period = exp_period(src, pres); it.tag = tag;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
  endtask

  task automatic setup_out(input int ch, input int src, input int pres, input string tag);
    logic [DW-1:0] r;
    int w;
    bus_write(ADDR_CLR, DW'(1 << ch));
    bus_write(cfg_addr(ch), DW'((pres << 4) | src));
    bus_read(cfg_addr(ch), r);
    check(r == DW'((pres << 4) | src), "R5 cfg readback", int'(r), (pres << 4) | src);
    bus_read(ADDR_RDY, r);
    check(r[ch] == 1'b0, "R8 ready cleared after write", int'(r[ch]), 0);
    w = 0;
    do begin bus_read(ADDR_RDY, r); w++; end while (!r[ch] && w < 100);
    check(r[ch] == 1'b1, "R8 ready sets", int'(r[ch]), 1);
    bus_write(ADDR_SET, DW'(1 << ch));
    expect_period(ch, src, pres, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    int h, w;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(ADDR_ON, r);  check(r == 0, "R1 on-status after reset", int'(r), 0);
    for (int c = 0; c < NUM_OUT; c++) begin
      bus_read(cfg_addr(c), r); check(r == 0, "R1 cfg after reset", int'(r), 0);
    end
    h = 0;
    for (int k = 0; k < 70; k++) begin #3; if (pck_o != 0) h++; end
    check(h == 0, "R1 outputs low after reset", h, 0);

    // R2/R4: enable output 0 with default config, slow clock divide 1
    bus_write(ADDR_SET, 8'h01);
    bus_read(ADDR_ON, r); check(r == 8'h01, "R4 on-status shows output 0", int'(r), 1);
    expect_period(0, 0, 0, "R6 slow div1");
    bus_write(ADDR_SET, 8'h02);
    bus_read(ADDR_ON, r); check(r == 8'h03, "R2 zero bits keep state", int'(r), 3);

    // R3: clear output 0, zero bits keep output 1
    bus_write(ADDR_CLR, 8'h01);
    bus_read(ADDR_ON, r); check(r == 8'h02, "R3 clear output 0", int'(r), 2);
    count_high(0, h); check(h == 0, "R3 off output low", h, 0);
    bus_write(ADDR_CLR, 8'h00);
    bus_read(ADDR_ON, r); check(r == 8'h02, "R3 zero bits keep state", int'(r), 2);
    bus_write(ADDR_CLR, 8'h02);

    // R5/R6: all sources and prescaler codes on output 0
    setup_out(0, 1, 1, "R6 main div2");
    setup_out(0, 2, 3, "R6 plla div8");
    setup_out(0, 3, 2, "R6 pllb div4");
    setup_out(0, 4, 6, "R6 master div64");
    setup_out(0, 0, 4, "R6 slow div16");
    setup_out(0, 1, 7, "R6 code 7 acts as div64");
    setup_out(0, 4, 0, "R5 master div1");
    bus_write(ADDR_CLR, 8'h01);
    count_high(0, h); check(h == 0, "R3 running output stops", h, 0);

    // R8: ready must not rise within one slow period
    bus_write(cfg_addr(2), 8'h00);
    repeat (14) @(negedge clk);
    bus_read(ADDR_RDY, r); check(r[2] == 1'b0, "R8 ready early", int'(r[2]), 0);
    w = 0;
    do begin bus_read(ADDR_RDY, r); w++; end while (!r[2] && w < 60);
    check(r[2] == 1'b1, "R8 ready after two slow edges", int'(r[2]), 1);

    // R7: reserved source on output 1
    bus_write(cfg_addr(1), 8'h05);
    bus_write(ADDR_SET, 8'h02);
    count_high(1, h); check(h == 0, "R7 reserved source low", h, 0);
    repeat (60) @(negedge clk);
    bus_read(ADDR_RDY, r); check(r[1] == 1'b0, "R7 reserved ready clear", int'(r[1]), 0);
    bus_write(cfg_addr(1), 8'h07);
    count_high(1, h); check(h == 0, "R7 code 7 low", h, 0);

    // R9: two outputs at once
    setup_out(1, 1, 0, "R9 output 1 main div1");
    setup_out(2, 3, 0, "R9 output 2 pllb div1");
    expect_period(1, 1, 0, "R9 output 1 unchanged");
    bus_write(ADDR_CLR, 8'h04);
    bus_write(cfg_addr(2), 8'h12);
    expect_period(1, 1, 0, "R9 output 1 after reconfig of 2");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule